// File: doc/BRIEF.md
# Frequency Window Lock Detector

This block decides whether a recovered serial clock runs at the rate it is meant to run at. A divided copy of the recovered clock arrives as an asynchronous input. The block counts its rising edges over a fixed gate of reference-clock cycles. The reference clock is 27 MHz. The block then compares the count with a tolerance window of ±2000 ppm around the expected count for the selected rate.

A 2-bit code selects the rate: SD at 270 Mb/s, HD at 1.485 Gb/s or 3G at 2.97 Gb/s. Each rate has its own divider ratio, so each has its own expected count. The block computes the expected count and the window bounds at elaboration time from the parameters. The loss-of-lock result drives a dedicated pin and also bit 0 of a small status word.

The flag changes only at the end of a gate. Lock needs consecutive good gates, while a single bad gate is enough to declare loss. A reset or any change of the rate code drops lock at once and starts a fresh gate.

Top module: `freq_window_lock_det`

## Requirements
- R1: While reset is asserted, and after its release until lock is qualified, `lol` is 1. The reset is asynchronous, so `lol` goes to 1 in the same instant that `rst_n` falls.
- R2: The rate code selects the rate as follows: 2'b01 is SD, 2'b10 is HD and 2'b11 is 3G. The expected count is GATE_CYCLES × rate / (27 MHz × divider), rounded to the nearest integer. The window runs from ceil(expected × 0.998) to floor(expected × 1.002). A recovered clock that sits at the expected count for the selected rate ends in lock.
- R3: Lock (`lol` = 0) needs two consecutive in-window gate measurements. One in-window measurement alone leaves `lol` at 1.
- R4: A single gate whose count falls below the window sets `lol` to 1 at the end of that gate.
- R5: A single gate whose count lies above the window sets `lol` to 1 at the end of that gate.
- R6: `lol` changes only one cycle after a gate completes, or on a rate-code change. It holds its value in mid-gate even when the input stops toggling.
- R7: A change of `rate_sel` sets `lol` to 1 on the next clock edge. The same change clears the qualification history and restarts the gate, so lock under the new code again needs two fresh in-window gates.
- R8: Rate code 2'b00 selects no rate. While it is applied, `lol` stays 1 whatever the input does.
- R9: The status word carries `lol` in bit 0 and the applied rate code in bits 2:1. All higher bits are 0.
- R10: An input at another rate's expected count does not give lock. For example, the SD signal with the HD code applied leaves `lol` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz reference clock; all state runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_div | input | 1 | Divided recovered clock, asynchronous to `clk` |
| rate_sel | input | 2 | Rate code: 00 none, 01 SD, 10 HD, 11 3G |
| lol | output | 1 | Loss-of-lock flag, 1 = not locked |
| status | output | STATUS_W | Bit 0 = `lol`, bits 2:1 = applied rate code, rest 0 |

## Verification
The bench builds the block with a gate of 1024 reference cycles. It sets the dividers to 40, 440 and 1760, so the expected counts are 256, 128 and 64 edges. These counts correspond to input periods of 4, 8 and 16 reference cycles, which the bench can produce exactly. With this short gate the ±2000 ppm window shrinks to the single expected count. One missing or extra edge per gate is therefore already out of window, and several gates fit into a short run. This makes it possible to check lock qualification, one-gate loss, restart on a code change and mismatched rates cycle by cycle against known gate boundaries.

// File: rtl/fwld_pkg.sv
package fwld_pkg;

   localparam longint REF_KHZ      = 27000;
   localparam longint SD_KBPS      = 270000;
   localparam longint HD_KBPS      = 1485000;
   localparam longint G3_KBPS      = 2970000;
   localparam longint PPM_SCALE    = 1000000;

   typedef enum logic [1:0] {
      RATE_NONE = 2'b00,
      RATE_SD   = 2'b01,
      RATE_HD   = 2'b10,
      RATE_3G   = 2'b11
   } rate_e;

   // Edges expected in one gate, rounded to nearest
   function automatic longint nominal_count(longint gate, longint kbps, longint div);
      longint den;
      den = REF_KHZ * div;
      return (gate * kbps + den / 2) / den;
   endfunction

   // Lower bound rounded up (inward)
   function automatic longint low_bound(longint nom, longint ppm);
      return (nom * (PPM_SCALE - ppm) + PPM_SCALE - 1) / PPM_SCALE;
   endfunction

   // Upper bound rounded down (inward)
   function automatic longint high_bound(longint nom, longint ppm);
      return (nom * (PPM_SCALE + ppm)) / PPM_SCALE;
   endfunction

endpackage

// File: rtl/fwld_edge_sync.sv
module fwld_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fwld_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
         prev  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~prev;

   // R2
   single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/fwld_gate_counter.sv
module fwld_gate_counter #(
   parameter int unsigned GATE_CYCLES = 16384,
   parameter int unsigned CNT_W       = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             rise,
   output logic             meas_valid,
   output logic [CNT_W-1:0] meas_count
);

   localparam int unsigned TMR_W = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;

   generate
      if (GATE_CYCLES < 4) begin : g_bad_gate
         $error("fwld_gate_counter: GATE_CYCLES must be at least 4");
      end
      if ((1 << CNT_W) <= GATE_CYCLES / 2) begin : g_bad_width
         $error("fwld_gate_counter: CNT_W too narrow for the gate");
      end
   endgenerate

   logic [TMR_W-1:0] tmr;
   logic [CNT_W-1:0] acc;
   logic             gate_end;

   assign gate_end = (tmr == TMR_W'(GATE_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr        <= '0;
         acc        <= '0;
         meas_valid <= 1'b0;
         meas_count <= '0;
      end else if (restart) begin
         tmr        <= '0;
         acc        <= '0;
         meas_valid <= 1'b0;
      end else begin
         meas_valid <= gate_end;
         if (gate_end) begin
            tmr        <= '0;
            acc        <= '0;
            meas_count <= acc + CNT_W'(rise);
         end else begin
            tmr <= tmr + TMR_W'(1);
            acc <= acc + CNT_W'(rise);
         end
      end
   end

   // R6
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |=> !meas_valid);

   // R2
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |-> (meas_count <= CNT_W'(GATE_CYCLES / 2 + 1)));

endmodule

// File: rtl/fwld_window_judge.sv
module fwld_window_judge
   import fwld_pkg::*;
#(
   parameter int unsigned GATE_CYCLES = 16384,
   parameter int unsigned CNT_W       = 15,
   parameter int unsigned DIV_SD      = 40,
   parameter int unsigned DIV_HD      = 440,
   parameter int unsigned DIV_3G      = 1760,
   parameter int unsigned TOL_PPM     = 2000,
   parameter int unsigned LOCK_RUNS   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  rate_e            rate,
   input  logic             meas_valid,
   input  logic [CNT_W-1:0] meas_count,
   output logic             lol
);

   localparam longint NOM_SD = nominal_count(longint'(GATE_CYCLES), SD_KBPS, longint'(DIV_SD));
   localparam longint NOM_HD = nominal_count(longint'(GATE_CYCLES), HD_KBPS, longint'(DIV_HD));
   localparam longint NOM_3G = nominal_count(longint'(GATE_CYCLES), G3_KBPS, longint'(DIV_3G));

   // Code 00 gets an empty window (low above high)
   localparam logic [CNT_W-1:0] LO_T [4] = '{
      CNT_W'(1),
      CNT_W'(low_bound(NOM_SD, longint'(TOL_PPM))),
      CNT_W'(low_bound(NOM_HD, longint'(TOL_PPM))),
      CNT_W'(low_bound(NOM_3G, longint'(TOL_PPM)))
   };
   localparam logic [CNT_W-1:0] HI_T [4] = '{
      CNT_W'(0),
      CNT_W'(high_bound(NOM_SD, longint'(TOL_PPM))),
      CNT_W'(high_bound(NOM_HD, longint'(TOL_PPM))),
      CNT_W'(high_bound(NOM_3G, longint'(TOL_PPM)))
   };

   generate
      if (2 * NOM_SD >= longint'(GATE_CYCLES) || 2 * NOM_HD >= longint'(GATE_CYCLES) ||
          2 * NOM_3G >= longint'(GATE_CYCLES)) begin : g_bad_ratio
         $error("fwld_window_judge: divided clock must stay below half the reference");
      end
      if (NOM_SD < 1 || NOM_HD < 1 || NOM_3G < 1) begin : g_bad_nom
         $error("fwld_window_judge: expected count rounds to zero");
      end
      if (TOL_PPM >= 1000000) begin : g_bad_tol
         $error("fwld_window_judge: tolerance out of range");
      end
      if (LOCK_RUNS < 1) begin : g_bad_runs
         $error("fwld_window_judge: LOCK_RUNS must be at least 1");
      end
   endgenerate

   logic in_win;
   assign in_win = (meas_count >= LO_T[rate]) && (meas_count <= HI_T[rate]);

   generate
      if (LOCK_RUNS == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          lol <= 1'b1;
            else if (restart)    lol <= 1'b1;
            else if (meas_valid) lol <= !in_win;
         end
      end else begin : g_multi
         localparam int unsigned RUN_W = $clog2(LOCK_RUNS + 1);
         logic [RUN_W-1:0] run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run <= '0;
               lol <= 1'b1;
            end else if (restart) begin
               run <= '0;
               lol <= 1'b1;
            end else if (meas_valid) begin
               if (!in_win) begin
                  run <= '0;
                  lol <= 1'b1;
               end else if (run >= RUN_W'(LOCK_RUNS - 1)) begin
                  lol <= 1'b0;
               end else begin
                  run <= run + RUN_W'(1);
               end
            end
         end
      end
   endgenerate

   // R3
   lock_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lol) |-> $past(meas_valid && in_win));

   // R4
   bad_gate_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_valid && !in_win) |=> lol);

   // R6
   gate_end_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lol) |-> $past(meas_valid || restart));

   // R8
   no_rate_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate == RATE_NONE) |-> lol);

endmodule

// File: rtl/freq_window_lock_det.sv
module freq_window_lock_det
   import fwld_pkg::*;
#(
   parameter int unsigned GATE_CYCLES = 16384,
   parameter int unsigned DIV_SD      = 40,
   parameter int unsigned DIV_HD      = 440,
   parameter int unsigned DIV_3G      = 1760,
   parameter int unsigned TOL_PPM     = 2000,
   parameter int unsigned LOCK_RUNS   = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STATUS_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rec_div,
   input  logic [1:0]          rate_sel,
   output logic                lol,
   output logic [STATUS_W-1:0] status
);

   localparam int unsigned CNT_W = $clog2(GATE_CYCLES + 1);

   generate
      if (STATUS_W < 3) begin : g_bad_status
         $error("freq_window_lock_det: STATUS_W must be at least 3");
      end
   endgenerate

   rate_e            rate_q;
   logic             restart;
   logic             rise;
   logic             meas_valid;
   logic [CNT_W-1:0] meas_count;

   assign restart = (rate_e'(rate_sel) != rate_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rate_q <= RATE_NONE;
      else        rate_q <= rate_e'(rate_sel);
   end

   fwld_edge_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (rec_div),
      .rise     (rise)
   );

   fwld_gate_counter #(
      .GATE_CYCLES (GATE_CYCLES),
      .CNT_W       (CNT_W)
   ) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .rise       (rise),
      .meas_valid (meas_valid),
      .meas_count (meas_count)
   );

   fwld_window_judge #(
      .GATE_CYCLES (GATE_CYCLES),
      .CNT_W       (CNT_W),
      .DIV_SD      (DIV_SD),
      .DIV_HD      (DIV_HD),
      .DIV_3G      (DIV_3G),
      .TOL_PPM     (TOL_PPM),
      .LOCK_RUNS   (LOCK_RUNS)
   ) u_judge (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .rate       (rate_q),
      .meas_valid (meas_valid),
      .meas_count (meas_count),
      .lol        (lol)
   );

   assign status = {{(STATUS_W-3){1'b0}}, rate_q, lol};

   // R7
   code_change_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> lol);

endmodule

// File: tb/freq_window_lock_det_test.sv
module freq_window_lock_det_test;

   localparam int unsigned G = 1024;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rec_div = 1'b0;
   logic [1:0] rate_sel = 2'b00;
   logic       lol;
   logic [7:0] status;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int half_q = 2;
   int ph = 0;
   bit paused = 1'b0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   freq_window_lock_det #(
      .GATE_CYCLES (G),
      .DIV_SD      (40),
      .DIV_HD      (440),
      .DIV_3G      (1760),
      .STATUS_W    (8)
   ) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .rec_div  (rec_div),
      .rate_sel (rate_sel),
      .lol      (lol),
      .status   (status)
   );

   always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

   // Stimulus: toggle every half_q cycles -> period 2*half_q
   always @(negedge clk) begin
      if (!paused) begin
         if (ph >= half_q - 1) begin
            ph <= 0;
            rec_div <= ~rec_div;
         end else begin
            ph <= ph + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic wait_until(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic apply_reset(input logic [1:0] code, input int half);
      @(negedge clk);
      rst_n = 1'b0;
      rate_sel = code;
      half_q = half;
      paused = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst_n = 1'b0;
      rate_sel = 2'b01;
      repeat (3) @(negedge clk);
      chk(lol == 1'b1, "R1 lol in reset", lol, 1);
      chk(status == 8'h01, "R9 status in reset", status, 8'h01);
      rst_n = 1'b1;
      wait_until(100);
      chk(lol == 1'b1, "R1 lol before first gate", lol, 1);
   endtask

   task automatic t_lock(input logic [1:0] code, input int half);
      apply_reset(code, half);
      wait_until(G + 10);
      chk(lol == 1'b1, "R3 one gate is not enough", lol, 1);
      wait_until(3 * G + 10);
      chk(lol == 1'b0, "R2 lock at expected count", lol, 0);
      chk(status == {5'b0, code, 1'b0}, "R9 status when locked", status, {5'b0, code, 1'b0});
   endtask

   task automatic t_slow_gate;
      apply_reset(2'b01, 2);
      wait_until(3 * G + 10);
      chk(lol == 1'b0, "R4 locked before slow gate", lol, 0);
      wait_until(3 * G + 200);
      #1 paused = 1'b1;
      wait_until(3 * G + 300);
      #1 paused = 1'b0;
      wait_until(3 * G + 400);
      chk(lol == 1'b0, "R6 no change mid-gate", lol, 0);
      wait_until(4 * G + 10);
      chk(lol == 1'b1, "R4 loss after one slow gate", lol, 1);
      wait_until(5 * G + 10);
      chk(lol == 1'b1, "R3 one good gate after loss", lol, 1);
      wait_until(6 * G + 10);
      chk(lol == 1'b0, "R3 relock after two good gates", lol, 0);
   endtask

   task automatic t_fast_gate;
      apply_reset(2'b10, 4);
      wait_until(3 * G + 10);
      chk(lol == 1'b0, "R5 locked on HD", lol, 0);
      wait_until(3 * G + 100);
      #1 half_q = 3;
      wait_until(3 * G + 500);
      chk(lol == 1'b0, "R6 holds until gate end", lol, 0);
      wait_until(4 * G + 10);
      chk(lol == 1'b1, "R5 loss after fast gate", lol, 1);
      wait_until(5 * G + 10);
      chk(lol == 1'b1, "R5 stays lost while fast", lol, 1);
   endtask

   task automatic t_rate_change;
      int c;
      apply_reset(2'b01, 2);
      wait_until(3 * G + 10);
      chk(lol == 1'b0, "R7 locked on SD", lol, 0);
      c = 3 * G + 50;
      wait_until(c);
      #1;
      rate_sel = 2'b10;
      half_q = 4;
      wait_until(c + 2);
      chk(lol == 1'b1, "R7 loss on code change", lol, 1);
      wait_until(c + G + 10);
      chk(lol == 1'b1, "R7 history cleared", lol, 1);
      wait_until(c + 3 * G + 10);
      chk(lol == 1'b0, "R7 relock under new code", lol, 0);
      chk(status == 8'h04, "R9 status after change", status, 8'h04);
   endtask

   task automatic t_no_rate;
      apply_reset(2'b00, 2);
      wait_until(3 * G + 10);
      chk(lol == 1'b1, "R8 code 00 keeps loss", lol, 1);
      wait_until(4 * G + 10);
      chk(lol == 1'b1, "R8 code 00 still loss", lol, 1);
      chk(status == 8'h01, "R9 status code 00", status, 8'h01);
   endtask

   task automatic t_mismatch;
      apply_reset(2'b10, 2);
      wait_until(3 * G + 10);
      chk(lol == 1'b1, "R10 SD signal with HD code", lol, 1);
      apply_reset(2'b11, 4);
      wait_until(3 * G + 10);
      chk(lol == 1'b1, "R10 HD signal with 3G code", lol, 1);
   endtask

   task automatic t_mid_reset;
      apply_reset(2'b11, 8);
      wait_until(3 * G + 10);
      chk(lol == 1'b0, "R1 locked on 3G", lol, 0);
      rst_n = 1'b0;
      #1;
      chk(lol == 1'b1, "R1 async reset drops lock", lol, 1);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      t_reset();
      t_lock(2'b01, 2);
      t_lock(2'b10, 4);
      t_lock(2'b11, 8);
      t_slow_gate();
      t_fast_gate();
      t_rate_change();
      t_no_rate();
      t_mismatch();
      t_mid_reset();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule